// File: doc/BRIEF.md
# Grouped Interrupt Summary Aggregator

This block collects the pending flags of a large set of pins and folds them into a short summary vector. Each summary bit stands for a group of four neighbouring pins. A handler therefore reads a few words to find which groups need attention, rather than walking every pin. The summary is held in a register stage. Software reads it through two 32-bit windows: one carries the lower summary bits and the other carries the remaining upper bits.

The same summary drives a single level interrupt line toward the processor. The line rises when any group is pending and the block is armed. Once raised, the line stays high and the block stays disarmed until software writes an end-of-interrupt (EOI) bit into a master register. Software writes EOI after it has cleared the per-pin status, which happens in the pin detectors outside this block. If any group is still pending at that moment, the line comes back one cycle after it drops. A late event is therefore never lost. The EOI bit acts as a one-cycle command and always reads back as zero.

Top module: `irqsum_top`

## Requirements
- R1: After reset the line is low, both summary windows read zero and the block is armed.
- R2: Summary bit k is the OR of the pending flags of pins 4k to 4k+3. It is registered, so it becomes visible one clock edge after the pin flags are sampled.
- R3: Reading address 0 returns summary bits 31:0, with summary bit i in data bit i.
- R4: Reading address 1 returns summary bits 45:32 in data bits 13:0. Data bits 31:14 read as zero, and address 3 reads as zero.
- R5: A summary bit stays set while any pin of its group is pending. It drops one edge after the last pin of the group clears.
- R6: While armed, the line rises on the edge after any summary bit is seen set, which is two edges after the pin flag is applied. It then stays high until EOI, even if the summary empties.
- R7: An EOI is a write to address 2 with data bit 29 set. It drops the line at that edge and re-arms the block. A write to address 2 without bit 29, or a write to any other address, does not change the line.
- R8: If any summary bit is set when the EOI lands, the line is low for exactly one cycle and then rises again.
- R9: The master register at address 2 always reads zero, including the EOI bit. The summary windows are read-only, so writes to them leave their contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_pending_i | input | 184 | Pending flag of each pin from the per-pin detectors |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 low window, 1 high window, 2 master, 3 unused |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The case that matters most is an EOI write landing in the same cycle as a group that is still pending, or that becomes pending. The release and the re-assertion then compete on consecutive edges. The bench holds one group pending, issues the EOI, and expects the line to be low for exactly one sampled cycle and high on the next. It also repeats the EOI while the summary is empty, and then expects the line to stay low. Sweeping every single pin and a set of random sparse patterns through both windows confirms the grouping arithmetic against a model inside the bench.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;

   typedef enum logic [1:0] {
      ADDR_SUM_LO = 2'd0,
      ADDR_SUM_HI = 2'd1,
      ADDR_MASTER = 2'd2,
      ADDR_RSVD   = 2'd3
   } irqsum_addr_e;

   localparam int unsigned REG_W_DEF      = 32;
   localparam int unsigned EOI_POS_DEF    = 29;
   localparam int unsigned MAX_SUM_WORDS  = 2;

endpackage

// File: rtl/irqsum_group_or.sv
module irqsum_group_or #(
   parameter int unsigned NUM_GROUPS     = 46,
   parameter int unsigned PINS_PER_GROUP = 4,
   parameter bit          REG_SUMMARY    = 1'b1,
   localparam int unsigned NUM_PINS      = NUM_GROUPS * PINS_PER_GROUP
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   pend_i,
   output logic [NUM_GROUPS-1:0] sum_o
);

   logic [NUM_GROUPS-1:0] grp_hit;

   initial begin
      if (NUM_GROUPS < 1) $error("NUM_GROUPS must be at least 1");
      if (PINS_PER_GROUP < 1) $error("PINS_PER_GROUP must be at least 1");
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_hit[g] = |pend_i[g*PINS_PER_GROUP +: PINS_PER_GROUP];
   end

   if (REG_SUMMARY) begin : g_reg
      logic [NUM_GROUPS-1:0] sum_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sum_q <= '0;
         else        sum_q <= grp_hit;
      end
      assign sum_o = sum_q;
   end else begin : g_comb
      assign sum_o = grp_hit;
   end

endmodule

// File: rtl/irqsum_regview.sv
module irqsum_regview
   import irqsum_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 46,
   parameter int unsigned REG_W      = REG_W_DEF,
   localparam int unsigned NUM_WORDS = (NUM_GROUPS + REG_W - 1) / REG_W,
   localparam int unsigned PAD_W     = NUM_WORDS * REG_W
) (
   input  logic [NUM_GROUPS-1:0] sum_i,
   input  logic [1:0]            addr_i,
   output logic [REG_W-1:0]      rdata_o
);

   logic [PAD_W-1:0] sum_pad;

   initial begin
      if (NUM_WORDS > MAX_SUM_WORDS) $error("summary does not fit the address map");
   end

   assign sum_pad = PAD_W'(sum_i);

   always_comb begin
      rdata_o = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (int'(addr_i) == w) rdata_o = sum_pad[w*REG_W +: REG_W];
      end
   end

endmodule

// File: rtl/irqsum_line_ctrl.sv
module irqsum_line_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic sum_any_i,
   input  logic eoi_i,
   output logic irq_o
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  irq_q <= 1'b0;
      else if (eoi_i)              irq_q <= 1'b0;
      else if (!irq_q && sum_any_i) irq_q <= 1'b1;
   end

   assign irq_o = irq_q;

   // R6: the line only rises when the summary was non-empty
   assert_rise_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(sum_any_i));

   // R6: the line holds until an EOI arrives
   assert_hold_until_eoi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !eoi_i) |=> irq_q);

   // R7: an EOI releases the line
   assert_eoi_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_i |=> !irq_q);

   // R8: a pending summary at release brings the line straight back
   assert_rearm_refire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_q) && sum_any_i && !eoi_i) |=> irq_q);

endmodule

// File: rtl/irqsum_top.sv
module irqsum_top
   import irqsum_pkg::*;
#(
   parameter int unsigned NUM_GROUPS     = 46,
   parameter int unsigned PINS_PER_GROUP = 4,
   parameter int unsigned REG_W          = REG_W_DEF,
   parameter int unsigned EOI_POS        = EOI_POS_DEF,
   parameter bit          REG_SUMMARY    = 1'b1,
   localparam int unsigned NUM_PINS      = NUM_GROUPS * PINS_PER_GROUP,
   localparam int unsigned HI_BITS       = (NUM_GROUPS > REG_W) ? NUM_GROUPS - REG_W : 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_pending_i,
   input  logic                reg_wr_i,
   input  logic [1:0]          reg_addr_i,
   input  logic [REG_W-1:0]    reg_wdata_i,
   output logic [REG_W-1:0]    reg_rdata_o,
   output logic                irq_o
);

   logic [NUM_GROUPS-1:0] sum;
   logic                  eoi;

   initial begin
      if (EOI_POS >= REG_W) $error("EOI_POS outside the master register");
      if (HI_BITS >= REG_W) $error("summary exceeds two windows");
   end

   irqsum_group_or #(
      .NUM_GROUPS    (NUM_GROUPS),
      .PINS_PER_GROUP(PINS_PER_GROUP),
      .REG_SUMMARY   (REG_SUMMARY)
   ) u_or (
      .clk   (clk),
      .rst_n (rst_n),
      .pend_i(pin_pending_i),
      .sum_o (sum)
   );

   irqsum_regview #(
      .NUM_GROUPS(NUM_GROUPS),
      .REG_W     (REG_W)
   ) u_view (
      .sum_i  (sum),
      .addr_i (reg_addr_i),
      .rdata_o(reg_rdata_o)
   );

   assign eoi = reg_wr_i && (reg_addr_i == ADDR_MASTER) && reg_wdata_i[EOI_POS];

   irqsum_line_ctrl u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .sum_any_i(|sum),
      .eoi_i    (eoi),
      .irq_o    (irq_o)
   );

   // R4: unused upper bits of the high window stay zero
   assert_hi_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == ADDR_SUM_HI) |-> ((reg_rdata_o >> HI_BITS) == '0));

   // R9: the master register never reads back a one
   assert_master_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == ADDR_MASTER) |-> (reg_rdata_o == '0));

   // R1: line is quiet on the first cycle out of reset
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq_o);

endmodule

// File: tb/tb_irqsum_top.sv
module tb_irqsum_top;

   localparam int CLK_PERIOD = 10;
   localparam int NG  = 46;
   localparam int PPG = 4;
   localparam int NP  = NG * PPG;
   localparam int EOI_BIT = 29;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pend = '0;
   logic          wr = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irqsum_top dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pin_pending_i(pend),
      .reg_wr_i     (wr),
      .reg_addr_i   (addr),
      .reg_wdata_i  (wdata),
      .reg_rdata_o  (rdata),
      .irq_o        (irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] model_sum(input logic [NP-1:0] p);
      logic [63:0] s = '0;
      for (int g = 0; g < NG; g++) s[g] = |p[g*PPG +: PPG];
      return s;
   endfunction

   task automatic read_sum(output logic [63:0] s);
      addr = 2'd0; #1; s[31:0] = rdata;
      addr = 2'd1; #1; s[63:32] = rdata;
      addr = 2'd0;
   endtask

   task automatic check_views(input logic [NP-1:0] p, input string tag);
      logic [63:0] got;
      logic [63:0] exp;
      exp = model_sum(p);
      read_sum(got);
      chk(got == exp, tag, got, exp);
   endtask

   task automatic do_eoi(input logic [1:0] a, input logic [31:0] d);
      wr = 1'b1; addr = a; wdata = d;
      tick();
      wr = 1'b0; addr = 2'd0; wdata = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] got;
      @(negedge clk);
      repeat (2) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(irq == 1'b0, "R1 line after reset", {63'd0, irq}, 64'd0);
      read_sum(got);
      chk(got == 64'd0, "R1 summary after reset", got, 64'd0);

      // R2 R3 R4 R5 R6 R7: sweep every pin alone
      for (int p = 0; p < NP; p++) begin
         pend = '0; pend[p] = 1'b1;
         tick();
         check_views(pend, (p < 128) ? "R3 single pin view" : "R4 single pin view");
         tick();
         chk(irq == 1'b1, "R6 line rises", {63'd0, irq}, 64'd1);
         pend = '0;
         tick();
         check_views(pend, "R5 group cleared");
         chk(irq == 1'b1, "R6 line held after clear", {63'd0, irq}, 64'd1);
         do_eoi(2'd2, 32'd1 << EOI_BIT);
         chk(irq == 1'b0, "R7 eoi releases", {63'd0, irq}, 64'd0);
         tick();
         chk(irq == 1'b0, "R7 stays low when empty", {63'd0, irq}, 64'd0);
      end

      // R4 upper pad and unused address
      pend = '1;
      tick();
      addr = 2'd1; #1;
      chk(rdata == 32'h0000_3fff, "R4 high window full", {32'd0, rdata}, 64'h3fff);
      addr = 2'd3; #1;
      chk(rdata == 32'd0, "R4 address 3 zero", {32'd0, rdata}, 64'd0);
      addr = 2'd0;

      // R5 group stays set until its last pin clears
      for (int k = 0; k < PPG; k++) begin
         pend = '0;
         for (int j = k; j < PPG; j++) pend[5*PPG + j] = 1'b1;
         tick();
         check_views(pend, "R5 partial group");
      end
      pend = '0;
      tick();
      check_views(pend, "R5 last pin cleared");
      do_eoi(2'd2, 32'd1 << EOI_BIT);
      tick();

      // R2 random sparse patterns
      for (int t = 0; t < 60; t++) begin
         for (int w = 0; w < NP; w += 32)
            for (int b = 0; b < 32 && w + b < NP; b++)
               pend[w+b] = ($urandom % 13) == 0;
         tick();
         check_views(pend, "R2 random pattern");
      end

      // R8 eoi while a group is still pending
      pend = '0; pend[100] = 1'b1;
      repeat (2) tick();
      chk(irq == 1'b1, "R8 line high before eoi", {63'd0, irq}, 64'd1);
      do_eoi(2'd2, 32'd1 << EOI_BIT);
      chk(irq == 1'b0, "R8 one low cycle", {63'd0, irq}, 64'd0);
      tick();
      chk(irq == 1'b1, "R8 line back", {63'd0, irq}, 64'd1);

      // R7 writes that are not an EOI
      do_eoi(2'd2, ~(32'd1 << EOI_BIT));
      chk(irq == 1'b1, "R7 master write without bit", {63'd0, irq}, 64'd1);
      do_eoi(2'd0, 32'hffff_ffff);
      chk(irq == 1'b1, "R7 eoi bit to low window", {63'd0, irq}, 64'd1);
      do_eoi(2'd1, 32'hffff_ffff);
      chk(irq == 1'b1, "R7 eoi bit to high window", {63'd0, irq}, 64'd1);

      // R9 summary read-only and master reads zero
      check_views(pend, "R9 summary unchanged by writes");
      wr = 1'b1; addr = 2'd2; wdata = 32'hffff_ffff; #1;
      chk(rdata == 32'd0, "R9 master reads zero during write", {32'd0, rdata}, 64'd0);
      tick();
      wr = 1'b0; wdata = '0; #1;
      chk(rdata == 32'd0, "R9 master reads zero after eoi", {32'd0, rdata}, 64'd0);
      addr = 2'd0;
      pend = '0;
      tick();
      do_eoi(2'd2, 32'd1 << EOI_BIT);
      tick();
      chk(irq == 1'b0, "R7 final release", {63'd0, irq}, 64'd0);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule